// File: doc/BRIEF.md
# Clock generator startup sequencer

This block is the digital controller beside a crystal-referenced clock synthesizer. It runs on the reference clock and walks the synthesizer through power-up. First comes a fixed settling wait so the oscillator can stabilise. Next comes a VCO calibration window of fixed length. The block then waits for the PLL to report lock, and only after that does it release the output buffers from high impedance.

A two-bit board strap chooses the output buffer format and whether a copy of the reference is driven out. The block samples the strap once, when reset is released. An output-enable pin can shut the core down at any time. When that pin is raised again, the whole settle and calibrate sequence runs again.

The reset and output-enable pins are asynchronous, so each passes through a two-flop synchronizer. The lock indication is taken as synchronous to the reference clock. A 3-bit state code is brought out so the sequence can be observed.

Top module: `clkgen_startup_seq`

## Requirements
- R1: While rst_n is low the block is in state code 0 (reset), with out_hiz=1, cal_en=0, core_pd=0 and lock_fail=0; asserting rst_n low takes effect without waiting for a clock edge.
- R2: After rst_n rises with oe high, the state code is still 0 after the second rising clock edge and becomes 1 (settle) at the third.
- R3: The settle state lasts exactly SETTLE_CYCLES (default 16384) clock edges, after which the state code becomes 2 (calibrate).
- R4: In calibrate, cal_en is 1; it stays 1 for exactly CAL_CYCLES (default 550) edges, after which the state code is 3 (wait for lock) and cal_en is 0.
- R5: In wait-for-lock, a high pll_locked at a rising edge moves the block to state code 4 (normal), and out_hiz becomes 0 at that edge.
- R6: If pll_locked stays low for LOCK_TIMEOUT (default 1024) edges in wait-for-lock, lock_fail is set and the block re-enters calibrate; lock_fail then stays 1 until rst_n is asserted.
- R7: mode_onehot decodes the latched strap as follows: bit 0 is set for os=00 (LVCMOS), bit 1 for os=01 (LVDS), and bit 2 for os=10 and os=11 (LVPECL). oscout_en is 1 only with strap 11 in state 4.
- R8: os is captured at the reset-release edge; later changes to os leave mode_onehot and oscout_en unchanged until the next reset.
- R9: When oe goes low outside reset, the state code becomes 5 (power-down) on the third rising edge; core_pd is then 1, out_hiz is 1, and cal_en and oscout_en are 0.
- R10: When oe rises in power-down, the state code becomes 1 on the third rising edge, and the full settle, calibrate and lock sequence runs again.
- R11: If oe is low when reset is released, the block goes to state code 5 instead of 1.
- R12: out_hiz is 1 in every state other than state code 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset pin |
| oe | input | 1 | Asynchronous output-enable pin; low requests shutdown |
| os | input | 2 | Output-format strap |
| pll_locked | input | 1 | PLL lock indication, synchronous to clk_ref |
| cal_en | output | 1 | VCO calibration window |
| core_pd | output | 1 | Core power-down request |
| out_hiz | output | 1 | Output buffers held at high impedance |
| mode_onehot | output | 3 | Buffer format, one-hot (LVCMOS, LVDS, LVPECL) |
| oscout_en | output | 1 | Reference passthrough enable |
| lock_fail | output | 1 | Sticky lock-timeout flag |
| state_code | output | 3 | Current sequencer state |

## Verification
A pin change on rst_n or oe needs two synchronizer edges and one state-register edge, so its effect on the state code is due on the third rising edge after the change. A lock indication acts on the next edge. Each settle, calibrate and timeout window ends on the edge that completes its count. The bench drives every input on a falling edge and advances a known number of rising edges before it samples, again on a falling edge. At each boundary it checks the last cycle before the expected change and then the first cycle after it, so a window that is one cycle off fails in either direction.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

    localparam int NUM_FMT = 3;

    typedef enum logic [2:0] {
        ST_RESET  = 3'd0,
        ST_SETTLE = 3'd1,
        ST_CAL    = 3'd2,
        ST_WLOCK  = 3'd3,
        ST_NORMAL = 3'd4,
        ST_PWRDN  = 3'd5
    } seq_state_e;

endpackage

// File: rtl/clkseq_sync.sv
module clkseq_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/clkseq_strap.sv
module clkseq_strap
    import clkseq_pkg::*;
(
    input  logic [1:0]         strap,
    input  logic               active,
    output logic [NUM_FMT-1:0] mode_onehot,
    output logic               oscout_en
);

    always_comb begin
        mode_onehot = '0;
        unique case (strap)
            2'b00:   mode_onehot[0] = 1'b1;
            2'b01:   mode_onehot[1] = 1'b1;
            default: mode_onehot[2] = 1'b1;
        endcase
        oscout_en = (strap == 2'b11) && active;
    end

endmodule

// File: rtl/clkseq_fsm.sv
module clkseq_fsm
    import clkseq_pkg::*;
#(
    parameter int SETTLE_CYCLES = 16384,
    parameter int CAL_CYCLES    = 550,
    parameter int LOCK_TIMEOUT  = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_s,
    input  logic       oe_s,
    input  logic [1:0] os,
    input  logic       pll_locked,
    output logic [1:0] strap,
    output logic       cal_en,
    output logic       core_pd,
    output logic       out_hiz,
    output logic       lock_fail,
    output logic [2:0] state_code
);

    localparam int MAX_A = (SETTLE_CYCLES > CAL_CYCLES) ? SETTLE_CYCLES : CAL_CYCLES;
    localparam int MAX_CNT = (MAX_A > LOCK_TIMEOUT) ? MAX_A : LOCK_TIMEOUT;
    localparam int CW = $clog2(MAX_CNT + 1);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYCLES - 1);
    localparam logic [CW-1:0] CAL_LAST    = CW'(CAL_CYCLES - 1);
    localparam logic [CW-1:0] LOCK_LAST   = CW'(LOCK_TIMEOUT - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic          rst_prev;
        logic          lock_fail;
        logic [1:0]    strap;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d          = seq_q;
        seq_d.rst_prev = rst_s;
        if (seq_q.st == ST_RESET) begin
            if (rst_s && !seq_q.rst_prev) begin
                seq_d.strap = os;
                seq_d.cnt   = '0;
                seq_d.st    = oe_s ? ST_SETTLE : ST_PWRDN;
            end
        end else if (!oe_s) begin
            seq_d.st  = ST_PWRDN;
            seq_d.cnt = '0;
        end else begin
            unique case (seq_q.st)
                ST_SETTLE: begin
                    if (seq_q.cnt == SETTLE_LAST) begin
                        seq_d.st  = ST_CAL;
                        seq_d.cnt = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
                ST_CAL: begin
                    if (seq_q.cnt == CAL_LAST) begin
                        seq_d.st  = ST_WLOCK;
                        seq_d.cnt = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
                ST_WLOCK: begin
                    if (pll_locked) begin
                        seq_d.st  = ST_NORMAL;
                        seq_d.cnt = '0;
                    end else if (seq_q.cnt == LOCK_LAST) begin
                        seq_d.st        = ST_CAL;
                        seq_d.cnt       = '0;
                        seq_d.lock_fail = 1'b1;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
                ST_PWRDN: begin
                    seq_d.st  = ST_SETTLE;
                    seq_d.cnt = '0;
                end
                ST_NORMAL: seq_d.st = ST_NORMAL;
                default: begin
                    seq_d.st  = ST_PWRDN;
                    seq_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_RESET, cnt: '0, rst_prev: 1'b0, lock_fail: 1'b0, strap: 2'b00};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign strap      = seq_q.strap;
    assign cal_en     = (seq_q.st == ST_CAL);
    assign core_pd    = (seq_q.st == ST_PWRDN);
    assign out_hiz    = (seq_q.st != ST_NORMAL);
    assign lock_fail  = seq_q.lock_fail;
    assign state_code = seq_q.st;

    p_settle_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_CAL && $past(seq_q.st) == ST_SETTLE) |-> ($past(seq_q.cnt) == SETTLE_LAST));

    p_cal_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_WLOCK && $past(seq_q.st) == ST_CAL) |-> ($past(seq_q.cnt) == CAL_LAST));

    p_lock_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_NORMAL && $past(seq_q.st) != ST_NORMAL)
            |-> ($past(seq_q.st) == ST_WLOCK && $past(pll_locked)));

    p_fail_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(seq_q.lock_fail) |-> seq_q.lock_fail);

    p_oe_pwrdn_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_s && seq_q.st != ST_RESET) |=> (seq_q.st == ST_PWRDN));

endmodule

// File: rtl/clkgen_startup_seq.sv
module clkgen_startup_seq
    import clkseq_pkg::*;
#(
    parameter int SETTLE_CYCLES = 16384,
    parameter int CAL_CYCLES    = 550,
    parameter int LOCK_TIMEOUT  = 1024,
    parameter int SYNC_STAGES   = 2
) (
    input  logic               clk_ref,
    input  logic               rst_n,
    input  logic               oe,
    input  logic [1:0]         os,
    input  logic               pll_locked,
    output logic               cal_en,
    output logic               core_pd,
    output logic               out_hiz,
    output logic [NUM_FMT-1:0] mode_onehot,
    output logic               oscout_en,
    output logic               lock_fail,
    output logic [2:0]         state_code
);

    logic [1:0] pins_s;
    logic [1:0] strap;

    clkseq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .din   ({oe, 1'b1}),
        .dout  (pins_s)
    );

    clkseq_fsm #(
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .CAL_CYCLES    (CAL_CYCLES),
        .LOCK_TIMEOUT  (LOCK_TIMEOUT)
    ) u_fsm (
        .clk        (clk_ref),
        .rst_n      (rst_n),
        .rst_s      (pins_s[0]),
        .oe_s       (pins_s[1]),
        .os         (os),
        .pll_locked (pll_locked),
        .strap      (strap),
        .cal_en     (cal_en),
        .core_pd    (core_pd),
        .out_hiz    (out_hiz),
        .lock_fail  (lock_fail),
        .state_code (state_code)
    );

    clkseq_strap u_strap (
        .strap       (strap),
        .active      (!out_hiz),
        .mode_onehot (mode_onehot),
        .oscout_en   (oscout_en)
    );

    p_osc_active_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        oscout_en |-> (!out_hiz && !core_pd));

    p_strap_held_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (state_code != 3'd0 && $past(state_code) != 3'd0) |-> $stable(mode_onehot));

endmodule

// File: tb/clkgen_startup_seq_test.sv
module clkgen_startup_seq_test;

    localparam int CLK_PERIOD = 40;
    localparam int WATCHDOG   = 150000;

    // Vector fields: os[5:4], mode_onehot[3:1], oscout_en[0]
    localparam logic [5:0] VEC [0:3] = '{
        6'b00_001_0,
        6'b01_010_0,
        6'b10_100_0,
        6'b11_100_1
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       oe;
    logic [1:0] os;
    logic       pll_locked;
    logic       cal_en, core_pd, out_hiz, oscout_en, lock_fail;
    logic [2:0] mode_onehot;
    logic [2:0] state_code;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkgen_startup_seq uut (
        .clk_ref     (clk),
        .rst_n       (rst_n),
        .oe          (oe),
        .os          (os),
        .pll_locked  (pll_locked),
        .cal_en      (cal_en),
        .core_pd     (core_pd),
        .out_hiz     (out_hiz),
        .mode_onehot (mode_onehot),
        .oscout_en   (oscout_en),
        .lock_fail   (lock_fail),
        .state_code  (state_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Release reset with the given strap and run to the wait-for-lock state.
    task automatic to_wait(input logic [1:0] strap_val);
        os         = strap_val;
        oe         = 1'b1;
        pll_locked = 1'b0;
        rst_n      = 1'b1;
        step(2);
        chk("R2 still reset after two edges", state_code, 0);
        step(1);
        chk("R2 settle on third edge", state_code, 1);
        chk("R12 hiz in settle", out_hiz, 1);
        step(16383);
        chk("R3 settle last cycle", state_code, 1);
        step(1);
        chk("R3 calibrate after settle", state_code, 2);
        chk("R4 cal_en in calibrate", cal_en, 1);
        chk("R12 hiz in calibrate", out_hiz, 1);
        step(549);
        chk("R4 calibrate last cycle", cal_en, 1);
        step(1);
        chk("R4 wait-lock after calibrate", state_code, 3);
        chk("R4 cal_en off", cal_en, 0);
        chk("R12 hiz in wait-lock", out_hiz, 1);
        chk("R7 passthrough off before normal", oscout_en, 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", WATCHDOG, 0);
        finish_run();
    end

    initial begin
        rst_n      = 1'b0;
        oe         = 1'b1;
        os         = 2'b00;
        pll_locked = 1'b0;
        step(5);
        chk("R1 reset state", state_code, 0);
        chk("R1 reset hiz", out_hiz, 1);
        chk("R1 reset cal_en", cal_en, 0);
        chk("R1 reset core_pd", core_pd, 0);
        chk("R1 reset lock_fail", lock_fail, 0);

        // Strap table: one full sequence per encoding
        for (int i = 0; i < 4; i++) begin
            to_wait(VEC[i][5:4]);
            pll_locked = 1'b1;
            step(1);
            chk("R5 normal after lock", state_code, 4);
            chk("R5 outputs active", out_hiz, 0);
            chk("R7 mode decode", mode_onehot, VEC[i][3:1]);
            chk("R7 passthrough", oscout_en, VEC[i][0]);
            #1 rst_n = 1'b0;
            #1;
            chk("R1 async reset", state_code, 0);
            pll_locked = 1'b0;
            step(1);
            chk("R1 reset hiz again", out_hiz, 1);
        end

        // Lock timeout
        to_wait(2'b11);
        step(1023);
        chk("R6 wait-lock last cycle", state_code, 3);
        chk("R6 no fail yet", lock_fail, 0);
        step(1);
        chk("R6 back to calibrate", state_code, 2);
        chk("R6 lock_fail set", lock_fail, 1);
        chk("R6 cal_en on retry", cal_en, 1);
        step(550);
        chk("R6 wait-lock after retry", state_code, 3);
        pll_locked = 1'b1;
        step(1);
        chk("R6 normal after retry", state_code, 4);
        chk("R6 lock_fail sticky", lock_fail, 1);

        // Shutdown, strap change ignored, rerun
        os = 2'b00;
        oe = 1'b0;
        step(2);
        chk("R9 still normal after two edges", state_code, 4);
        step(1);
        chk("R9 power-down", state_code, 5);
        chk("R9 core_pd", core_pd, 1);
        chk("R9 hiz", out_hiz, 1);
        chk("R9 cal_en off", cal_en, 0);
        chk("R9 passthrough off", oscout_en, 0);
        chk("R8 mode held after strap change", mode_onehot, 3'b100);
        pll_locked = 1'b0;
        step(10);
        chk("R9 stays in power-down", state_code, 5);
        oe = 1'b1;
        step(2);
        chk("R10 still power-down after two edges", state_code, 5);
        step(1);
        chk("R10 settle on third edge", state_code, 1);
        chk("R10 core_pd released", core_pd, 0);
        step(16383);
        chk("R10 settle full length", state_code, 1);
        step(1);
        chk("R10 calibrate", state_code, 2);
        step(550);
        chk("R10 wait-lock", state_code, 3);
        pll_locked = 1'b1;
        step(1);
        chk("R10 normal again", state_code, 4);
        chk("R8 mode unchanged", mode_onehot, 3'b100);
        chk("R8 passthrough unchanged", oscout_en, 1);

        // Reset clears lock_fail; release with oe low
        rst_n = 1'b0;
        pll_locked = 1'b0;
        step(1);
        chk("R1 lock_fail cleared", lock_fail, 0);
        chk("R1 state reset", state_code, 0);
        oe    = 1'b0;
        rst_n = 1'b1;
        step(3);
        chk("R11 power-down at release", state_code, 5);
        chk("R11 core_pd", core_pd, 1);
        chk("R8 strap captured at release", mode_onehot, 3'b001);
        oe = 1'b1;
        step(3);
        chk("R10 settle from power-down", state_code, 1);

        finish_run();
    end

endmodule